// File: doc/BRIEF.md
# Pulse-Width Capture Timer

This block is a 16-bit up-counter with two modes of use. In free-run mode it counts enabled clock ticks and flips an output pin every time the count wraps from all ones back to zero, giving a square wave. In width mode it times the high phase of an input signal. The count starts on the rising edge and is frozen into a buffer on the falling edge. A completion flag and an overrun flag tell software whether a result is waiting and whether one was lost.

Software reaches the block through a small register port with two word addresses. Address 0 is the control/status word and address 1 is the result buffer. Several status bits change when they are accessed. Reading the buffer clears the completion and overrun flags. The wrap flag is cleared by writing a 0 to it. The output bit can only be written while the counter is halted. Two level interrupt lines report completion and wrap, each gated by its own enable bit.

Top module: `pulse_width_timer`

## Requirements
- R1: After reset, the control/status word reads 0, `bus_rdata` is 0, and `pulse_out`, `irq_end` and `irq_ovf` are 0.
- R2: A control write with bit0=1 and bit1=1 starts the counter. A control write with bit1=0 halts it. A control write with bit0=0 and bit1=1 leaves the run state unchanged. Bits 1:0 read back as 11 while running and as 00 while halted.
- R3: A start write clears the count to 0, including when the counter is already running. In free-run mode, the wrap flag (control bit5) sets on the 65536th clock edge after the start write at which `tick` is 1. Edges with `tick` at 0 do not advance the count.
- R4: A control write with bit5=0 clears the wrap flag, and a write with bit5=1 leaves it unchanged. A read with `bus_rmw`=1 returns bit5 as 1.
- R5: In free-run mode (control bit2=0), `pulse_out` inverts in the same cycle that the wrap flag sets.
- R6: The output level (control bit8, driven on `pulse_out`) is reset to 0 and takes the written value only while the counter is halted. A write while running leaves it unchanged.
- R7: In width mode (bit2=1), while running, the buffer receives the number of clock edges with both the input and `tick` sampled high, counted from the rising edge up to the falling edge. When the falling edge is sampled, the completion flag (bit3) sets.
- R8: A read of address 1 returns the buffer and clears the completion flag (bit3) and the overrun flag (bit7).
- R9: If a width result completes while the completion flag is still set, the buffer is overwritten with the new result and the overrun flag sets.
- R10: `irq_end` equals completion flag AND end-enable (bit4), and `irq_ovf` equals wrap flag AND wrap-enable (bit6), on every cycle.
- R11: While the counter is halted, input pulses produce no result and do not set the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one per counted step |
| pulse_in | input | 1 | Input whose high time is measured |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next cycle |
| bus_rmw | input | 1 | Marks a read as the first half of a read-modify-write |
| bus_addr | input | 1 | 0 = control/status, 1 = result buffer |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pulse_out | output | 1 | Output level, flipped on each wrap in free-run mode |
| irq_end | output | 1 | Measurement-complete interrupt request level |
| irq_ovf | output | 1 | Wrap interrupt request level |

## Verification
The bench places the wrap exactly: it restarts a running counter part way through, inserts idle-tick cycles, and checks that nothing has happened after 65535 counted steps and that the flag and the output flip come on the next step. A design that does not clear the count on restart, or that counts idle cycles, wraps early. Random pulse trains with a random count enable exercise the capture count, overrun and read-clear. An off-by-one at the rising or falling edge, or an overrun flag that ignores the pending-result state, shows up as a wrong buffer value or a wrong bit7. The write-zero-to-clear rule, the read-modify-write view, output writes made while running, and pulses arriving while halted are each tested directly, so a flag cleared by a 1 or an output bit that follows writes at any time is reported.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  // control/status word bit positions
  localparam int B_GO     = 0;
  localparam int B_HALTN  = 1;
  localparam int B_MODE   = 2;
  localparam int B_ENDF   = 3;
  localparam int B_ENDEN  = 4;
  localparam int B_OVFF   = 5;
  localparam int B_OVFEN  = 6;
  localparam int B_ERR    = 7;
  localparam int B_POUT   = 8;
  localparam int CTRL_BITS = 9;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_BUF  = 1'b1;

  // packed view of the status word, MSB first
  typedef struct packed {
    logic pout;
    logic err;
    logic ovf_en;
    logic ovf_f;
    logic end_en;
    logic end_f;
    logic mode;
    logic halt_n;
    logic go;
  } ctrl_t;
endpackage

// File: rtl/pwt_edge.sv
module pwt_edge #(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic prev;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh <= '0;
        end else begin
          sh[0] <= din;
          for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
        end
      end
      assign level = sh[SYNC_STAGES-1];
    end else begin : g_direct
      assign level = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/pwt_count.sv
module pwt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             width_mode,
  input  logic             restart,
  input  logic             rise,
  input  logic             fall,
  output logic             ovf_hit,
  output logic             cap_hit,
  output logic [CNT_W-1:0] cap_val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             meas;
  logic             active;
  logic             step;

  always_comb begin
    active  = run && !restart;
    cap_hit = active && width_mode && meas && fall;
    step    = active && tick &&
              (width_mode ? (meas && !fall && !rise) : 1'b1);
    ovf_hit = step && (cnt == CNT_MAX);
    cap_val = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      meas <= 1'b0;
    end else if (!run) begin
      meas <= 1'b0;
    end else if (width_mode) begin
      if (rise) begin
        cnt  <= {{(CNT_W-1){1'b0}}, tick};
        meas <= 1'b1;
      end else if (cap_hit) begin
        cnt  <= '0;
        meas <= 1'b0;
      end else if (step) begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      meas <= 1'b0;
      if (step) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwt_regs.sv
module pwt_regs
  import pwt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_rmw,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ovf_hit,
  input  logic              cap_hit,
  input  logic [CNT_W-1:0]  cap_val,
  output logic              run,
  output logic              width_mode,
  output logic              restart,
  output logic              end_f,
  output logic              err_f,
  output logic              ovf_f,
  output logic              end_en,
  output logic              ovf_en,
  output logic              pout,
  output logic [DATA_W-1:0] rdata
);
  logic             wr_ctrl;
  logic             rd_buf;
  logic [CNT_W-1:0] buf_q;
  ctrl_t            st;
  logic [DATA_W-1:0] rd_word;
  logic             unused_wbits;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_buf  = bus_rd && (bus_addr == ADDR_BUF);
  assign restart = wr_ctrl && bus_wdata[B_GO] && bus_wdata[B_HALTN];
  assign unused_wbits = ^{bus_wdata[DATA_W-1:CTRL_BITS],
                          bus_wdata[B_ENDF], bus_wdata[B_ERR]};

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      width_mode <= 1'b0;
      end_en     <= 1'b0;
      ovf_en     <= 1'b0;
    end else if (wr_ctrl) begin
      if (!bus_wdata[B_HALTN])    run <= 1'b0;
      else if (bus_wdata[B_GO])   run <= 1'b1;
      width_mode <= bus_wdata[B_MODE];
      end_en     <= bus_wdata[B_ENDEN];
      ovf_en     <= bus_wdata[B_OVFEN];
    end
  end

  // output level: software owns it while halted, wraps own it while running
  always_ff @(posedge clk) begin
    if (rst)                        pout <= 1'b0;
    else if (wr_ctrl && !run)       pout <= bus_wdata[B_POUT];
    else if (ovf_hit && !width_mode) pout <= ~pout;
  end

  // wrap flag: a new wrap beats a clearing write
  always_ff @(posedge clk) begin
    if (rst)                              ovf_f <= 1'b0;
    else if (ovf_hit)                     ovf_f <= 1'b1;
    else if (wr_ctrl && !bus_wdata[B_OVFF]) ovf_f <= 1'b0;
  end

  // capture buffer and its flags
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      end_f <= 1'b0;
      err_f <= 1'b0;
    end else begin
      if (cap_hit) buf_q <= cap_val;
      if (cap_hit)     end_f <= 1'b1;
      else if (rd_buf) end_f <= 1'b0;
      if (cap_hit && end_f && !rd_buf) err_f <= 1'b1;
      else if (rd_buf)                 err_f <= 1'b0;
    end
  end

  always_comb begin
    st.pout   = pout;
    st.err    = err_f;
    st.ovf_en = ovf_en;
    st.ovf_f  = ovf_f | bus_rmw;
    st.end_en = end_en;
    st.end_f  = end_f;
    st.mode   = width_mode;
    st.halt_n = run;
    st.go     = run;
    rd_word   = '0;
    if (bus_addr == ADDR_BUF) rd_word[CNT_W-1:0]     = buf_q;
    else                      rd_word[CTRL_BITS-1:0] = st;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (bus_rd) rdata <= rd_word;
  end
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              pulse_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_rmw,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pulse_out,
  output logic              irq_end,
  output logic              irq_ovf
);
  logic             in_lvl, in_rise, in_fall;
  logic             run, width_mode, restart;
  logic             ovf_hit, cap_hit;
  logic [CNT_W-1:0] cap_val;
  logic             end_f, err_f, ovf_f, end_en, ovf_en;

  pwt_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .din(pulse_in),
    .level(in_lvl), .rise(in_rise), .fall(in_fall)
  );

  pwt_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst(rst), .tick(tick), .run(run),
    .width_mode(width_mode), .restart(restart),
    .rise(in_rise), .fall(in_fall),
    .ovf_hit(ovf_hit), .cap_hit(cap_hit), .cap_val(cap_val)
  );

  pwt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ovf_hit(ovf_hit), .cap_hit(cap_hit), .cap_val(cap_val),
    .run(run), .width_mode(width_mode), .restart(restart),
    .end_f(end_f), .err_f(err_f), .ovf_f(ovf_f),
    .end_en(end_en), .ovf_en(ovf_en), .pout(pulse_out),
    .rdata(bus_rdata)
  );

  logic unused_lvl;
  assign unused_lvl = in_lvl;

  assign irq_end = end_f & end_en;
  assign irq_ovf = ovf_f & ovf_en;
endmodule

// File: rtl/pwt_chk.sv
module pwt_chk (
  input logic clk,
  input logic rst,
  input logic bus_wr,
  input logic bus_rd,
  input logic bus_addr,
  input logic wd_ovf,
  input logic run,
  input logic width_mode,
  input logic ovf_hit,
  input logic cap_hit,
  input logic end_f,
  input logic err_f,
  input logic ovf_f,
  input logic pulse_out
);
  // R4
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_f) |-> $past(bus_wr && !bus_addr && !wd_ovf));

  // R5
  pout_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && (pulse_out != $past(pulse_out)))
      |-> $past(ovf_hit && !width_mode));

  // R7
  end_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(end_f) |-> $past(cap_hit));

  // R8
  end_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(end_f) |-> $past(bus_rd && bus_addr));

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_f) |-> $past(end_f && cap_hit));

  // R11
  halted_cap_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !cap_hit);
endmodule

bind pulse_width_timer pwt_chk chk_i (
  .clk(clk), .rst(rst),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .wd_ovf(bus_wdata[pwt_pkg::B_OVFF]),
  .run(run), .width_mode(width_mode),
  .ovf_hit(ovf_hit), .cap_hit(cap_hit),
  .end_f(end_f), .err_f(err_f), .ovf_f(ovf_f),
  .pulse_out(pulse_out)
);

// File: tb/pulse_width_timer_tb_top.sv
module pulse_width_timer_tb_top;
  localparam logic [15:0] W_GO = 16'h0001, W_HALTN = 16'h0002,
    W_MODE = 16'h0004, W_ENDEN = 16'h0010, W_OVFF = 16'h0020,
    W_OVFEN = 16'h0040, W_POUT = 16'h0100;

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 1'b0, pulse_in = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic pulse_out, irq_end, irq_ovf;

  int nchk = 0, nbad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pulse_width_timer dut_i (
    .clk(clk), .rst(rst), .tick(tick), .pulse_in(pulse_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pulse_out(pulse_out), .irq_end(irq_end), .irq_ovf(irq_ovf)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic t);
    pulse_in = p; tick = t;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; pulse_in = 1'b0; tick = 1'b0;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic rmw, output logic [15:0] d);
    bus_addr = a; bus_rmw = rmw; bus_rd = 1'b1; pulse_in = 1'b0; tick = 1'b0;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; bus_rmw = 1'b0;
    d = bus_rdata;
  endtask

  // bench model of the capture path
  logic        exp_end = 0, exp_err = 0;
  logic [15:0] exp_buf = 0;

  function automatic logic [15:0] model_capture(input logic [15:0] acc);
    if (exp_end) exp_err = 1'b1;
    exp_end = 1'b1;
    exp_buf = acc;
    return acc;
  endfunction

  // one pulse of high length len; tick random or forced 1
  task automatic send_pulse(input int len, input bit rnd_tick, output logic [15:0] acc);
    acc = 0;
    for (int k = 0; k < len; k++) begin
      logic t;
      t = rnd_tick ? logic'($urandom % 2) : 1'b1;
      cyc(1'b1, t);
      acc += {15'd0, t};
    end
    cyc(1'b0, 1'b1);
  endtask

  initial begin
    logic [15:0] d, acc, dummy;
    void'($urandom(32'd20240607));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 outs", {bus_rdata, pulse_out, irq_end, irq_ovf}, 0);
    rd(1'b0, 1'b0, d);
    check("R1 ctrl", d, 0);

    // R2 go=0 halt_n=1 does not start
    wr(1'b0, W_HALTN);
    rd(1'b0, 1'b0, d);
    check("R2 nostart", d[1:0], 2'b00);

    // R6 output written while halted
    wr(1'b0, W_HALTN | W_POUT);
    rd(1'b0, 1'b0, d);
    check("R6 halted write", {d[8], pulse_out}, 2'b11);
    wr(1'b0, W_HALTN);
    check("R6 halted clear", pulse_out, 0);

    // width mode start, R2
    wr(1'b0, W_GO | W_HALTN | W_MODE | W_ENDEN);
    rd(1'b0, 1'b0, d);
    check("R2 running", {d[2], d[1:0]}, 3'b111);

    // R6 write while running ignored
    wr(1'b0, W_HALTN | W_MODE | W_ENDEN | W_POUT);
    rd(1'b0, 1'b0, d);
    check("R6 running write", {d[8], pulse_out, d[1:0]}, 4'b0011);

    // random pulse trains, R7 R8 R9 R10
    for (int i = 0; i < 40; i++) begin
      int len, act;
      len = 1 + int'($urandom % 24);
      send_pulse(len, 1'b1, acc);
      dummy = model_capture(acc);
      check("R10 irq_end", irq_end, exp_end);
      repeat ($urandom % 3) cyc(1'b0, 1'b1);
      act = int'($urandom % 4);
      if (act == 0) begin
        rd(1'b0, 1'b0, d);
        check("R7 end flag", d[3], exp_end);
        check("R9 err flag", d[7], exp_err);
      end else if (act == 1) begin
        rd(1'b1, 1'b0, d);
        check("R7 R9 buffer", d, exp_buf);
        exp_end = 0; exp_err = 0;
        rd(1'b0, 1'b0, d);
        check("R8 flags cleared", {d[7], d[3], irq_end}, 3'b000);
      end
    end

    // directed overrun, R9 then R8
    rd(1'b1, 1'b0, d);
    exp_end = 0; exp_err = 0;
    send_pulse(5, 1'b0, acc);
    send_pulse(3, 1'b0, acc);
    rd(1'b0, 1'b0, d);
    check("R9 overrun set", {d[7], d[3]}, 2'b11);
    rd(1'b1, 1'b0, d);
    check("R9 overwritten", d, 16'd3);
    rd(1'b0, 1'b0, d);
    check("R8 read clears", {d[7], d[3]}, 2'b00);

    // R10 enable off masks irq_end
    wr(1'b0, W_HALTN | W_MODE);
    send_pulse(4, 1'b0, acc);
    check("R10 masked", irq_end, 0);
    rd(1'b0, 1'b0, d);
    check("R10 flag under mask", d[3], 1);
    rd(1'b1, 1'b0, d);
    check("R7 len4", d, 16'd4);

    // R11 halted ignores pulses
    wr(1'b0, W_MODE);
    rd(1'b0, 1'b0, d);
    check("R2 halted", d[1:0], 2'b00);
    send_pulse(6, 1'b0, acc);
    rd(1'b0, 1'b0, d);
    check("R11 no capture", d[3], 0);

    // free-run mode, R3 R5
    wr(1'b0, 16'h0000);
    wr(1'b0, W_GO | W_HALTN | W_OVFEN | W_OVFF);
    repeat (30000) cyc(1'b0, 1'b1);
    wr(1'b0, W_GO | W_HALTN | W_OVFEN | W_OVFF); // restart
    for (int k = 0; k < 65535; k++) begin
      cyc(1'b0, 1'b1);
      if (k % 4096 == 0) cyc(1'b0, 1'b0);
    end
    check("R3 no early wrap", {pulse_out, irq_ovf}, 2'b00);
    cyc(1'b0, 1'b1);
    check("R5 pout flip", pulse_out, 1);
    check("R10 irq_ovf", irq_ovf, 1);
    rd(1'b0, 1'b0, d);
    check("R3 wrap flag", d[5], 1);

    // R4 write-zero-to-clear
    wr(1'b0, W_HALTN | W_OVFEN | W_OVFF);
    rd(1'b0, 1'b0, d);
    check("R4 write1 keeps", d[5], 1);
    wr(1'b0, W_HALTN | W_OVFEN);
    rd(1'b0, 1'b0, d);
    check("R4 write0 clears", {d[5], irq_ovf}, 2'b00);
    rd(1'b0, 1'b1, d);
    check("R4 rmw view", d[5], 1);

    // R6 running write in free-run mode ignored
    wr(1'b0, W_HALTN | W_OVFEN);
    check("R6 running keep", pulse_out, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule